// File: doc/BRIEF.md
# Frame-Synchronous Mode Control Sampler

This block combines each external mode pin with the control-register bit that shares its function, and applies the result to the downstream voice-processing stages only at frame boundaries. It covers five controls: line-codec power-down, automatic gain control enable for the line and acoustic echo paths, noise-canceler bypass, slope-filter bypass and pad-stage enable. Each raw pin first passes through a synchronizer into the master-clock domain. The merged value is taken as a logical OR, so any pin that is not in use must be tied to 0 and left to the register.

The frame sync input is synchronized and edge-detected. On each rising edge the merged modes are captured into output registers, and those registers hold steady until the next rising edge. The line power-down control follows a separate rule. A request that differs from the value already applied does not take effect. Instead it raises a sticky pending flag, and the new value is applied at the first frame sample after a reset. The reset can come from the hard reset pin or from a register reset strobe.

Top module: `modeFrameSampler`

## Requirements
- R1: Every mode is the OR of its pin and its register bit. A register bit alone asserts its function while the pin is 0, and the two gain-control register bits act independently, one for each echo path.
- R2: Line power-down is active high. A merged value of 1 sets `lineDown`, which means the line codec is off. A merged value of 0 clears it.
- R3: The gain-control pin is active low. `agcEnLine` is the inverse of (`pinGainOff` OR `regGainOffLine`), and `agcEnAcou` is the inverse of (`pinGainOff` OR `regGainOffAcou`).
- R4: For `noiseBypass` and `slopeBypass`, a merged value of 1 selects through mode and a merged value of 0 selects normal processing.
- R5: `padEnable` is 1 (pad operation) when the merged pad input is 1, and 0 (through mode) when both the pad pin and the pad register bit are 0.
- R6: Between two rising edges of `frameSync`, every mode output holds its value whatever the pins and register bits do.
- R7: When the inputs are steady, the outputs take their new values at the third rising clock edge that samples `frameSync` high. They do not change at the second such edge.
- R8: At a frame sample with no reset armed, a merged power-down value that differs from `lineDown` leaves `lineDown` unchanged and sets `lineDownPending`. The flag stays set even if the request is later withdrawn.
- R9: A one-cycle `swReset` clears `lineDownPending` on the next clock edge. The next frame sample then loads `lineDown` from the merged power-down value.
- R10: After `rstN` is released, `lineDown` is 1 and every other output is 0. The first frame sample after release loads `lineDown` from the merged power-down value.
- R11: If `swReset` is high in the same cycle as a frame sample, the other modes still update and pending clears, but `lineDown` keeps its value. The load moves to the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| frameSync | input | 1 | Raw frame sync; its rising edge samples the modes |
| swReset | input | 1 | Register reset strobe, synchronous to clk |
| pinLineDown | input | 1 | Raw line power-down pin, 1 = down |
| pinGainOff | input | 1 | Raw gain-control pin, 1 = gain control off |
| pinNoiseBypass | input | 1 | Raw noise-canceler bypass pin, 1 = through |
| pinSlopeBypass | input | 1 | Raw slope-filter bypass pin, 1 = through |
| pinPadEnable | input | 1 | Raw pad pin, 1 = pad operation |
| regLineDown | input | 1 | Register power-down bit |
| regGainOffLine | input | 1 | Register gain-off bit for the line path |
| regGainOffAcou | input | 1 | Register gain-off bit for the acoustic path |
| regNoiseBypass | input | 1 | Register noise bypass bit |
| regSlopeBypass | input | 1 | Register slope bypass bit |
| regPadEnable | input | 1 | Register pad enable bit |
| lineDown | output | 1 | Applied line-codec power-down |
| lineDownPending | output | 1 | A power-down change is waiting for a reset |
| agcEnLine | output | 1 | Gain control enabled, line path |
| agcEnAcou | output | 1 | Gain control enabled, acoustic path |
| noiseBypass | output | 1 | Noise canceler in through mode |
| slopeBypass | output | 1 | Slope filter in through mode |
| padEnable | output | 1 | Pad stages in operation |

## Verification
A wrong arm flag shows up in the first frame after a reset. `lineDown` then either keeps its reset value of 1 or follows a later frame that it should have ignored. A wrong polarity in any merge shows up in the very next frame sample as an inverted output, and the stimulus separates pin-only cases from register-only cases for this reason. An edge detector that fires too early or too often shows up within three clock edges of a sync rise, or whenever pins change while sync is held steady. A pending flag that fails to stick shows up one frame after a power-down request is withdrawn.

// File: rtl/modeSamplePkg.sv
package modeSamplePkg;

  // positions inside the synchronized pin vector
  localparam int IDX_LINE_DOWN = 0;
  localparam int IDX_GAIN_OFF  = 1;
  localparam int IDX_NOISE_BYP = 2;
  localparam int IDX_SLOPE_BYP = 3;
  localparam int IDX_PAD_EN    = 4;
  localparam int NUM_PINS      = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleNow;   // frame boundary: capture merged modes
    logic loadPower;   // armed frame: apply power-down request
    logic rearm;       // register reset: clear pending
  } ctrlStrobe_t;

  typedef struct packed {
    logic lineDown;
    logic agcEnLine;
    logic agcEnAcou;
    logic noiseBypass;
    logic slopeBypass;
    logic padEnable;
  } modeSet_t;

endpackage

// File: rtl/modeSyncChain.sv
module modeSyncChain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/modeFrameCtrl.sv
module modeFrameCtrl
  import modeSamplePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSyncRaw,
  input  logic        swReset,
  output ctrlStrobe_t strobe
);

  logic syncNow;
  logic syncDly;
  logic armed;
  logic syncRise;

  modeSyncChain #(.WIDTH(1), .STAGES(SYNC_STAGES)) uSyncFrame (
    .clk  (clk),
    .rstN (rstN),
    .din  (frameSyncRaw),
    .dout (syncNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncDly <= 1'b0;
    else       syncDly <= syncNow;
  end

  assign syncRise = syncNow & ~syncDly;

  // armed after any reset, disarmed by the first frame that loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  armed <= 1'b1;
    else if (swReset)           armed <= 1'b1;
    else if (syncRise)          armed <= 1'b0;
  end

  always_comb begin
    strobe.sampleNow = syncRise;
    strobe.rearm     = swReset;
    strobe.loadPower = syncRise & armed & ~swReset;
  end

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleNow |=> !strobe.sampleNow); // R6
  AST_REARM_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> armed); // R9
  AST_LOAD_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPower |=> !armed); // R10
  AST_SIMUL_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (swReset && strobe.sampleNow) |-> !strobe.loadPower); // R11

endmodule

// File: rtl/modeMergeDatapath.sv
module modeMergeDatapath
  import modeSamplePkg::*;
#(
  parameter int   SYNC_STAGES   = 2,
  parameter logic DOWN_AT_RESET = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  logic                regLineDown,
  input  logic                regGainOffLine,
  input  logic                regGainOffAcou,
  input  logic                regNoiseBypass,
  input  logic                regSlopeBypass,
  input  logic                regPadEnable,
  input  ctrlStrobe_t         strobe,
  output modeSet_t            modeQ,
  output logic                pendingQ
);

  logic [NUM_PINS-1:0] pinS;
  modeSet_t            merged;

  modeSyncChain #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) uSyncPins (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinRaw),
    .dout (pinS)
  );

  always_comb begin
    merged.lineDown    = pinS[IDX_LINE_DOWN] | regLineDown;
    merged.agcEnLine   = ~(pinS[IDX_GAIN_OFF] | regGainOffLine);
    merged.agcEnAcou   = ~(pinS[IDX_GAIN_OFF] | regGainOffAcou);
    merged.noiseBypass = pinS[IDX_NOISE_BYP] | regNoiseBypass;
    merged.slopeBypass = pinS[IDX_SLOPE_BYP] | regSlopeBypass;
    merged.padEnable   = pinS[IDX_PAD_EN] | regPadEnable;
  end

  // ordinary modes: captured at every frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ.agcEnLine   <= 1'b0;
      modeQ.agcEnAcou   <= 1'b0;
      modeQ.noiseBypass <= 1'b0;
      modeQ.slopeBypass <= 1'b0;
      modeQ.padEnable   <= 1'b0;
    end else if (strobe.sampleNow) begin
      modeQ.agcEnLine   <= merged.agcEnLine;
      modeQ.agcEnAcou   <= merged.agcEnAcou;
      modeQ.noiseBypass <= merged.noiseBypass;
      modeQ.slopeBypass <= merged.slopeBypass;
      modeQ.padEnable   <= merged.padEnable;
    end
  end

  // power-down: applied only on an armed frame, otherwise flagged
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ.lineDown <= DOWN_AT_RESET;
      pendingQ       <= 1'b0;
    end else if (strobe.rearm) begin
      pendingQ <= 1'b0;
    end else if (strobe.loadPower) begin
      modeQ.lineDown <= merged.lineDown;
      pendingQ       <= 1'b0;
    end else if (strobe.sampleNow) begin
      pendingQ <= pendingQ | (merged.lineDown != modeQ.lineDown);
    end
  end

  AST_MODES_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleNow |=> $stable({modeQ.agcEnLine, modeQ.agcEnAcou,
      modeQ.noiseBypass, modeQ.slopeBypass, modeQ.padEnable})); // R6
  AST_DOWN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPower |=> $stable(modeQ.lineDown)); // R8
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rearm || strobe.loadPower) |=> !pendingQ); // R9
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !strobe.rearm && !strobe.loadPower) |=> pendingQ); // R8

endmodule

// File: rtl/modeFrameSampler.sv
module modeFrameSampler
  import modeSamplePkg::*;
#(
  parameter int   SYNC_STAGES   = 2,
  parameter logic DOWN_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameSync,
  input  logic swReset,
  input  logic pinLineDown,
  input  logic pinGainOff,
  input  logic pinNoiseBypass,
  input  logic pinSlopeBypass,
  input  logic pinPadEnable,
  input  logic regLineDown,
  input  logic regGainOffLine,
  input  logic regGainOffAcou,
  input  logic regNoiseBypass,
  input  logic regSlopeBypass,
  input  logic regPadEnable,
  output logic lineDown,
  output logic lineDownPending,
  output logic agcEnLine,
  output logic agcEnAcou,
  output logic noiseBypass,
  output logic slopeBypass,
  output logic padEnable
);

  ctrlStrobe_t         strobe;
  modeSet_t            modeQ;
  logic [NUM_PINS-1:0] pinRaw;

  always_comb begin
    pinRaw                = '0;
    pinRaw[IDX_LINE_DOWN] = pinLineDown;
    pinRaw[IDX_GAIN_OFF]  = pinGainOff;
    pinRaw[IDX_NOISE_BYP] = pinNoiseBypass;
    pinRaw[IDX_SLOPE_BYP] = pinSlopeBypass;
    pinRaw[IDX_PAD_EN]    = pinPadEnable;
  end

  modeFrameCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameSyncRaw (frameSync),
    .swReset      (swReset),
    .strobe       (strobe)
  );

  modeMergeDatapath #(.SYNC_STAGES(SYNC_STAGES), .DOWN_AT_RESET(DOWN_AT_RESET)) uPath (
    .clk            (clk),
    .rstN           (rstN),
    .pinRaw         (pinRaw),
    .regLineDown    (regLineDown),
    .regGainOffLine (regGainOffLine),
    .regGainOffAcou (regGainOffAcou),
    .regNoiseBypass (regNoiseBypass),
    .regSlopeBypass (regSlopeBypass),
    .regPadEnable   (regPadEnable),
    .strobe         (strobe),
    .modeQ          (modeQ),
    .pendingQ       (lineDownPending)
  );

  assign lineDown    = modeQ.lineDown;
  assign agcEnLine   = modeQ.agcEnLine;
  assign agcEnAcou   = modeQ.agcEnAcou;
  assign noiseBypass = modeQ.noiseBypass;
  assign slopeBypass = modeQ.slopeBypass;
  assign padEnable   = modeQ.padEnable;

endmodule

// File: tb/modeFrameSampler_test.sv
`timescale 1ns/1ps
module modeFrameSampler_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0;
  logic swReset = 1'b0;
  logic pinLineDown = 0, pinGainOff = 0, pinNoiseBypass = 0, pinSlopeBypass = 0, pinPadEnable = 0;
  logic regLineDown = 0, regGainOffLine = 0, regGainOffAcou = 0, regNoiseBypass = 0,
        regSlopeBypass = 0, regPadEnable = 0;
  logic lineDown, lineDownPending, agcEnLine, agcEnAcou, noiseBypass, slopeBypass, padEnable;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the power-down rule
  bit mArmed = 1, mApplied = 1, mPending = 0;

  typedef struct { logic [6:0] vec; string tag; } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  modeFrameSampler uut (.*);

  function automatic logic [6:0] outVec();
    return {lineDown, lineDownPending, agcEnLine, agcEnAcou, noiseBypass, slopeBypass, padEnable};
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chkVec(string tag, logic [6:0] act, logic [6:0] exp);
    chk({tag, " R2"}, "lineDown", act[6], exp[6]);
    chk({tag, " R8"}, "lineDownPending", act[5], exp[5]);
    chk({tag, " R3"}, "agcEnLine", act[4], exp[4]);
    chk({tag, " R3"}, "agcEnAcou", act[3], exp[3]);
    chk({tag, " R4"}, "noiseBypass", act[2], exp[2]);
    chk({tag, " R4"}, "slopeBypass", act[1], exp[1]);
    chk({tag, " R5"}, "padEnable", act[0], exp[0]);
  endtask

  task automatic setIn(logic [4:0] p, logic [5:0] r);
    @(negedge clk);
    {pinLineDown, pinGainOff, pinNoiseBypass, pinSlopeBypass, pinPadEnable} = p;
    {regLineDown, regGainOffLine, regGainOffAcou, regNoiseBypass, regSlopeBypass, regPadEnable} = r;
    repeat (4) @(negedge clk);
  endtask

  // compute expected outputs for a frame sample, from the requirements
  task automatic pushExp(string tag, bit simulReset);
    logic pd;
    logic [6:0] e;
    pd = pinLineDown | regLineDown;
    if (simulReset) begin
      mArmed = 1; mPending = 0;                  // R11
    end else if (mArmed) begin
      mApplied = pd; mPending = 0; mArmed = 0;   // R10 R9
    end else begin
      mPending = mPending | (pd != mApplied);    // R8
    end
    e = {mApplied, mPending, ~(pinGainOff | regGainOffLine), ~(pinGainOff | regGainOffAcou),
         pinNoiseBypass | regNoiseBypass, pinSlopeBypass | regSlopeBypass,
         pinPadEnable | regPadEnable};
    expQ.push_back('{e, tag});
  endtask

  task automatic frame(string tag);
    pushExp(tag, 0);
    frameSync = 1'b1;
    repeat (6) @(negedge clk);
    frameSync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: output valid after third edge seeing sync high
  initial begin
    forever begin
      @(posedge frameSync);
      repeat (3) @(posedge clk);
      #1;
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R6 unexpected sample actual=%b expected=none", outVec());
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        chkVec(it.tag, outVec(), it.vec);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chkVec("R10 reset", outVec(), 7'b1000000);

    setIn(5'b00000, 6'b000000);
    frame("R10 first load");                 // lineDown -> 0, agc on

    setIn(5'b01101, 6'b000000);
    frame("R1 pins only");                   // gain off, noise bypass, pad on

    setIn(5'b00000, 6'b010011);
    frame("R1 regs only");                   // line agc off only, slope, pad

    setIn(5'b00010, 6'b001000);
    frame("R1 acoustic reg");

    setIn(5'b10000, 6'b000000);
    frame("R8 request down");                // pending, lineDown held 0

    setIn(5'b00000, 6'b000000);
    frame("R8 sticky");

    // R6: input changes without sync edge have no effect
    snap = outVec();
    setIn(5'b11111, 6'b111111);
    repeat (10) @(negedge clk);
    chkVec("R6 held", outVec(), snap);

    // R9: register reset clears pending, next frame loads
    setIn(5'b10000, 6'b000000);
    swReset = 1'b1;
    @(negedge clk);
    swReset = 1'b0;
    mArmed = 1; mPending = 0;
    chk("R9", "pending after swReset", lineDownPending, 1'b0);
    frame("R9 load down");                   // lineDown -> 1

    // R11: swReset coincides with the sample
    setIn(5'b01000, 6'b000000);
    pushExp("R11 simul", 1);
    frameSync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    swReset = 1'b1;
    @(negedge clk);
    swReset = 1'b0;
    repeat (4) @(negedge clk);
    frameSync = 1'b0;
    repeat (4) @(negedge clk);
    frame("R11 deferred load");              // lineDown -> 0 now

    // R7: no change at second edge, change at third
    setIn(5'b00100, 6'b000000);
    pushExp("R7 latency", 0);
    frameSync = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R7", "noiseBypass at edge 2", noiseBypass, 1'b0);
    repeat (6) @(negedge clk);
    frameSync = 1'b0;
    repeat (4) @(negedge clk);

    // R10: hard reset mid-run
    setIn(5'b00000, 6'b100000);
    frame("R8 reg request");
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mArmed = 1; mApplied = 1; mPending = 0;
    @(negedge clk);
    chkVec("R10 re-reset", outVec(), 7'b1000000);
    setIn(5'b00000, 6'b000000);
    frame("R10 reload");

    repeat (5) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R7 missing samples actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule